// File: doc/BRIEF.md
# Row-Hit-First DRAM Request Picker

This block chooses which pending DRAM request a memory controller should serve next. It sees a small queue of requests, and each entry carries a valid bit, a bank, a row and a read/write flag. It also sees per-bank state from a bank timing tracker: whether a row is open, which row is open, how many cycles remain before a read or a write column command is allowed, and how many cycles remain before an activate is allowed. Rank is folded into the bank number, so one bank id names one physical bank.

The picker first looks for a ready row hit. A ready row hit is a request whose bank has its row open, whose row matches that open row, and whose column command is allowed now. It defers such a hit when another queued request wants a different row in the same bank, because that case needs a precharge decision. When no ready hit exists, it estimates for each bank with waiting requests when that bank could burst. The estimate is the activate wait plus `T_RCD`. It then marks the best banks in a mask. If any bank is seamless, meaning it can burst back-to-back with the data bus occupancy that remains, all seamless banks are marked. Otherwise the banks sharing the earliest estimate are marked. The oldest request to a marked bank wins. Age follows queue index, and index 0 is the oldest.

The choice is made combinationally and registered once per clock.

Top module: `dram_req_picker`

## Requirements
- R1: While `rst_ni` is low, `pick_valid_o`, `pick_idx_o` and `pick_hit_o` are all zero. The asynchronous reset takes effect without waiting for a clock edge.
- R2: If no queue entry is valid at a clock edge, `pick_valid_o` is 0 after that edge.
- R3: When one or more ready row hits exist, the lowest-index one is picked with `pick_hit_o`=1, ahead of any seamless or earlier bank.
- R4: A row hit is ready only if all of the following hold:
  - its bank has a row open;
  - the entry row equals that bank's open row;
  - the wait for its direction is zero. A read (`q_write_i` bit 0) uses `rd_wait_i`, and a write (bit 1) uses `wr_wait_i`.
- R5: A row hit is not treated as ready when another valid entry targets the same bank with a different row. Entries to other banks never defer it.
- R6: With no ready row hit, a bank is seamless when `act_wait + T_RCD <= bus_busy_i`. If any waiting bank is seamless, only seamless banks are candidates, even if a non-seamless bank has an earlier estimate.
- R7: With no ready hit and no seamless bank, the candidates are all waiting banks whose estimate equals the minimum estimate.
- R8: Among candidate requests, the valid entry with the lowest index is picked. Invalid entries are never picked and do not make a bank waiting.
- R9: The outputs are registered. They reflect the inputs present at the previous rising edge and hold between edges. When any entry is valid, `pick_valid_o` is 1 after the edge.
- Field packing: entry e uses `q_bank_i[e*BANK_W +: BANK_W]` and `q_row_i[e*ROW_W +: ROW_W]`. Bank b uses `bank_row_i[b*ROW_W +: ROW_W]` and `*_wait_i[b*TIME_W +: TIME_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| q_valid_i | input | NUM_ENTRIES | Entry valid bits |
| q_bank_i | input | NUM_ENTRIES*BANK_W | Entry bank ids |
| q_row_i | input | NUM_ENTRIES*ROW_W | Entry rows |
| q_write_i | input | NUM_ENTRIES | 1 = write, 0 = read |
| bank_open_i | input | NUM_BANKS | Bank has a row open |
| bank_row_i | input | NUM_BANKS*ROW_W | Open row per bank |
| rd_wait_i | input | NUM_BANKS*TIME_W | Cycles until a read column command is allowed |
| wr_wait_i | input | NUM_BANKS*TIME_W | Cycles until a write column command is allowed |
| act_wait_i | input | NUM_BANKS*TIME_W | Cycles until an activate is allowed |
| bus_busy_i | input | TIME_W | Cycles the data bus stays occupied |
| pick_valid_o | output | 1 | A request was picked |
| pick_idx_o | output | IDX_W | Picked queue index |
| pick_hit_o | output | 1 | Pick came from the ready-row-hit path |

## Verification
A ready row hit and a seamless fallback bank can both exist in the same cycle. The bench provokes this by keeping a hit ready while it opens a large bus occupancy window, and it judges the result by requiring the hit entry with `pick_hit_o`=1. The conflict check and the hit detection also coincide whenever a hit's bank holds a second request for another row. The bench builds that case and expects the fallback path, which is flagged by `pick_hit_o`=0. It also builds the same pattern spread over two banks, and there the hit must still win. Seamless preference is separated from earliest preference by one vector that differs only in `bus_busy_i`, so each rule yields a different index.

// File: rtl/dram_pick_pkg.sv
`timescale 1ns/1ps
package dram_pick_pkg;
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pick_first_set.sv
`timescale 1ns/1ps
module pick_first_set #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = dram_pick_pkg::idx_w(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end

  // R8
  oldest_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> (req_i[idx_o] && ((req_i & ((N'(1) << idx_o) - N'(1))) == '0)));
endmodule

// File: rtl/pick_hit_scan.sv
`timescale 1ns/1ps
module pick_hit_scan #(
  parameter int unsigned NE     = 8,
  parameter int unsigned NB     = 8,
  parameter int unsigned ROW_W  = 8,
  parameter int unsigned TIME_W = 6,
  localparam int unsigned BW = dram_pick_pkg::idx_w(NB)
) (
  input  logic [NE-1:0]     valid_i,
  input  logic [BW-1:0]     bank_i  [NE],
  input  logic [ROW_W-1:0]  row_i   [NE],
  input  logic [NE-1:0]     write_i,
  input  logic [NB-1:0]     open_i,
  input  logic [ROW_W-1:0]  orow_i  [NB],
  input  logic [TIME_W-1:0] rdw_i   [NB],
  input  logic [TIME_W-1:0] wrw_i   [NB],
  output logic [NE-1:0]     hit_o
);
  for (genvar i = 0; i < NE; i++) begin : g_ent
    logic conflict;
    logic [TIME_W-1:0] cwait;

    always_comb begin
      conflict = 1'b0;
      for (int j = 0; j < NE; j++) begin
        if (j != i && valid_i[j] && bank_i[j] == bank_i[i] && row_i[j] != row_i[i])
          conflict = 1'b1;
      end
    end

    assign cwait    = write_i[i] ? wrw_i[bank_i[i]] : rdw_i[bank_i[i]];
    assign hit_o[i] = valid_i[i] && open_i[bank_i[i]] && (row_i[i] == orow_i[bank_i[i]])
                      && (cwait == '0) && !conflict;
  end
endmodule

// File: rtl/pick_bank_mask.sv
`timescale 1ns/1ps
module pick_bank_mask #(
  parameter int unsigned NB     = 8,
  parameter int unsigned TIME_W = 6,
  parameter int unsigned T_RCD  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NB-1:0]     wait_i,
  input  logic [TIME_W-1:0] actw_i [NB],
  input  logic [TIME_W-1:0] bus_busy_i,
  output logic [NB-1:0]     mask_o
);
  localparam int unsigned EW = TIME_W + 1;

  logic [EW-1:0] est [NB];
  logic [NB-1:0] seam;
  logic [EW-1:0] min_est;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign est[b]  = {1'b0, actw_i[b]} + EW'(T_RCD);
    assign seam[b] = wait_i[b] && (est[b] <= {1'b0, bus_busy_i});
  end

  always_comb begin
    min_est = '1;
    for (int b = 0; b < NB; b++) begin
      if (wait_i[b] && est[b] < min_est) min_est = est[b];
    end
  end

  // seamless banks win as a group; otherwise all banks tied at the earliest estimate
  always_comb begin
    mask_o = '0;
    for (int b = 0; b < NB; b++) begin
      if (|seam) mask_o[b] = seam[b];
      else       mask_o[b] = wait_i[b] && (est[b] == min_est);
    end
  end

  // R7
  mask_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wait_i) |-> (|mask_o));
  // R8
  mask_in_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_o & ~wait_i) == '0);
endmodule

// File: rtl/dram_req_picker.sv
`timescale 1ns/1ps
module dram_req_picker #(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned NUM_BANKS   = 8,
  parameter int unsigned ROW_W       = 8,
  parameter int unsigned TIME_W      = 6,
  parameter int unsigned T_RCD       = 3,
  localparam int unsigned BANK_W = dram_pick_pkg::idx_w(NUM_BANKS),
  localparam int unsigned IDX_W  = dram_pick_pkg::idx_w(NUM_ENTRIES)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_ENTRIES-1:0]        q_valid_i,
  input  logic [NUM_ENTRIES*BANK_W-1:0] q_bank_i,
  input  logic [NUM_ENTRIES*ROW_W-1:0]  q_row_i,
  input  logic [NUM_ENTRIES-1:0]        q_write_i,
  input  logic [NUM_BANKS-1:0]          bank_open_i,
  input  logic [NUM_BANKS*ROW_W-1:0]    bank_row_i,
  input  logic [NUM_BANKS*TIME_W-1:0]   rd_wait_i,
  input  logic [NUM_BANKS*TIME_W-1:0]   wr_wait_i,
  input  logic [NUM_BANKS*TIME_W-1:0]   act_wait_i,
  input  logic [TIME_W-1:0]             bus_busy_i,
  output logic                          pick_valid_o,
  output logic [IDX_W-1:0]              pick_idx_o,
  output logic                          pick_hit_o
);
  localparam int unsigned NE = NUM_ENTRIES;
  localparam int unsigned NB = NUM_BANKS;

  logic [BANK_W-1:0] ent_bank [NE];
  logic [ROW_W-1:0]  ent_row  [NE];
  logic [ROW_W-1:0]  orow     [NB];
  logic [TIME_W-1:0] rdw      [NB];
  logic [TIME_W-1:0] wrw      [NB];
  logic [TIME_W-1:0] actw     [NB];

  for (genvar e = 0; e < NE; e++) begin : g_unpack_ent
    assign ent_bank[e] = q_bank_i[e*BANK_W +: BANK_W];
    assign ent_row[e]  = q_row_i[e*ROW_W +: ROW_W];
  end
  for (genvar b = 0; b < NB; b++) begin : g_unpack_bank
    assign orow[b] = bank_row_i[b*ROW_W +: ROW_W];
    assign rdw[b]  = rd_wait_i[b*TIME_W +: TIME_W];
    assign wrw[b]  = wr_wait_i[b*TIME_W +: TIME_W];
    assign actw[b] = act_wait_i[b*TIME_W +: TIME_W];
  end

  logic [NE-1:0]    hit_vec, fb_req;
  logic [NB-1:0]    bank_wait, bank_mask;
  logic             hit_found, fb_found;
  logic [IDX_W-1:0] hit_idx, fb_idx;

  pick_hit_scan #(.NE(NE), .NB(NB), .ROW_W(ROW_W), .TIME_W(TIME_W)) u_hit (
    .valid_i(q_valid_i), .bank_i(ent_bank), .row_i(ent_row), .write_i(q_write_i),
    .open_i(bank_open_i), .orow_i(orow), .rdw_i(rdw), .wrw_i(wrw), .hit_o(hit_vec)
  );

  always_comb begin
    bank_wait = '0;
    for (int e = 0; e < NE; e++) begin
      if (q_valid_i[e]) bank_wait[ent_bank[e]] = 1'b1;
    end
  end

  pick_bank_mask #(.NB(NB), .TIME_W(TIME_W), .T_RCD(T_RCD)) u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni), .wait_i(bank_wait), .actw_i(actw),
    .bus_busy_i(bus_busy_i), .mask_o(bank_mask)
  );

  always_comb begin
    for (int e = 0; e < NE; e++) fb_req[e] = q_valid_i[e] && bank_mask[ent_bank[e]];
  end

  pick_first_set #(.N(NE)) u_hit_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(hit_vec), .found_o(hit_found), .idx_o(hit_idx)
  );
  pick_first_set #(.N(NE)) u_fb_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(fb_req), .found_o(fb_found), .idx_o(fb_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pick_valid_o <= 1'b0;
      pick_idx_o   <= '0;
      pick_hit_o   <= 1'b0;
    end else begin
      pick_valid_o <= hit_found || fb_found;
      pick_idx_o   <= hit_found ? hit_idx : (fb_found ? fb_idx : '0);
      pick_hit_o   <= hit_found;
    end
  end

  // R2
  empty_no_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|q_valid_i) |=> !pick_valid_o);
  // R9
  pick_when_any_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|q_valid_i) |=> pick_valid_o);
  // R8
  pick_entry_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pick_valid_o |-> (|(($past(q_valid_i) >> pick_idx_o) & NE'(1))));
endmodule

// File: tb/tb_dram_req_picker.sv
`timescale 1ns/1ps
module tb_dram_req_picker;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0]  q_valid, q_write, bank_open, bus_busy;
  logic [7:0]  q_bank;
  logic [15:0] q_row, bank_row, rd_wait, wr_wait, act_wait;
  logic        pick_valid, pick_hit;
  logic [1:0]  pick_idx;

  dram_req_picker #(.NUM_ENTRIES(4), .NUM_BANKS(4), .ROW_W(4), .TIME_W(4), .T_RCD(2)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .q_valid_i(q_valid), .q_bank_i(q_bank), .q_row_i(q_row),
    .q_write_i(q_write), .bank_open_i(bank_open), .bank_row_i(bank_row),
    .rd_wait_i(rd_wait), .wr_wait_i(wr_wait), .act_wait_i(act_wait), .bus_busy_i(bus_busy),
    .pick_valid_o(pick_valid), .pick_idx_o(pick_idx), .pick_hit_o(pick_hit)
  );

  typedef struct packed {
    logic [3:0]  valid;
    logic [7:0]  bank;
    logic [15:0] row;
    logic [3:0]  wr;
    logic [3:0]  open;
    logic [15:0] orow;
    logic [15:0] rdw;
    logic [15:0] wrw;
    logic [15:0] actw;
    logic [3:0]  bus;
    logic        ev;
    logic [1:0]  eidx;
    logic        eh;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'hF, 8'hE4, 16'h9325, 4'h0, 4'hF, 16'h4321, 16'h0000, 16'h0000, 16'h0000, 4'd0,  1'b1, 2'd1, 1'b1}, // R3 oldest ready hit
    '{4'hF, 8'hE4, 16'h9325, 4'h0, 4'hF, 16'h4321, 16'h0030, 16'h0000, 16'h0000, 4'd0,  1'b1, 2'd2, 1'b1}, // R4 read wait blocks
    '{4'hF, 8'hE4, 16'h9325, 4'h6, 4'hF, 16'h4321, 16'h0000, 16'h0010, 16'h0000, 4'd0,  1'b1, 2'd2, 1'b1}, // R4 write wait blocks
    '{4'h3, 8'h05, 16'h0072, 4'h0, 4'hF, 16'h4321, 16'h0000, 16'h0000, 16'h0000, 4'd0,  1'b1, 2'd0, 1'b0}, // R5 conflict defers
    '{4'hF, 8'h93, 16'h0000, 4'h0, 4'hF, 16'h4321, 16'h0000, 16'h0000, 16'h4781, 4'd6,  1'b1, 2'd0, 1'b0}, // R6 seamless group
    '{4'hF, 8'h93, 16'h0000, 4'h0, 4'hF, 16'h4321, 16'h0000, 16'h0000, 16'h4781, 4'd0,  1'b1, 2'd1, 1'b0}, // R7 earliest
    '{4'hF, 8'h93, 16'h0000, 4'h0, 4'hF, 16'h4321, 16'h0000, 16'h0000, 16'h1781, 4'd0,  1'b1, 2'd0, 1'b0}, // R7 tie
    '{4'hE, 8'h68, 16'h0000, 4'h0, 4'hF, 16'h4321, 16'h0000, 16'h0000, 16'h0050, 4'd0,  1'b1, 2'd1, 1'b0}, // R8 same bank oldest
    '{4'h0, 8'hE4, 16'h4321, 4'h0, 4'hF, 16'h4321, 16'h0000, 16'h0000, 16'h0000, 4'd0,  1'b0, 2'd0, 1'b0}, // R2 empty
    '{4'hF, 8'hE4, 16'h4321, 4'h0, 4'hF, 16'h4321, 16'h0000, 16'h0000, 16'h0000, 4'd0,  1'b1, 2'd0, 1'b1}, // R3 all hit
    '{4'hE, 8'hE4, 16'h4321, 4'h0, 4'hF, 16'h4321, 16'h0000, 16'h0000, 16'h0000, 4'd0,  1'b1, 2'd1, 1'b1}, // R8 invalid skipped
    '{4'hF, 8'hE4, 16'h9325, 4'h0, 4'hD, 16'h4321, 16'h0000, 16'h0000, 16'h0000, 4'd0,  1'b1, 2'd2, 1'b1}, // R4 closed bank
    '{4'hF, 8'hE4, 16'h9325, 4'h0, 4'hF, 16'h4321, 16'h0000, 16'h0000, 16'h0000, 4'd15, 1'b1, 2'd1, 1'b1}, // R3 hit beats seamless
    '{4'h3, 8'h09, 16'h0072, 4'h0, 4'hF, 16'h4321, 16'h0000, 16'h0000, 16'h0000, 4'd0,  1'b1, 2'd0, 1'b1}  // R5 other bank no defer
  };

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    q_valid = v.valid; q_bank = v.bank; q_row = v.row; q_write = v.wr;
    bank_open = v.open; bank_row = v.orow; rd_wait = v.rdw; wr_wait = v.wrw;
    act_wait = v.actw; bus_busy = v.bus;
  endtask

  function automatic logic [7:0] outs();
    return {4'b0, pick_valid, pick_hit, pick_idx};
  endfunction

  initial begin
    apply(VECS[0]);
    #12;
    // R1 outputs held clear in reset with valid inputs present
    check("R1 reset outputs", outs(), 8'h00);
    @(negedge clk);
    rst_ni = 1'b1;
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      apply(VECS[k]);
      @(posedge clk);
      #1;
      check($sformatf("vector %0d (see table tag)", k), outs(),
            {4'b0, VECS[k].ev, VECS[k].eh, VECS[k].eidx});
    end
    // R9 output holds until the next edge
    @(negedge clk);
    apply(VECS[0]);
    @(posedge clk);
    #1;
    check("R9 first pick", outs(), {4'b0, 1'b1, 1'b1, 2'd1});
    apply(VECS[9]);
    #1;
    check("R9 hold between edges", outs(), {4'b0, 1'b1, 1'b1, 2'd1});
    @(posedge clk);
    #1;
    check("R9 update at edge", outs(), {4'b0, 1'b1, 1'b1, 2'd0});
    // R1 asynchronous reset mid-cycle
    rst_ni = 1'b0;
    #1;
    check("R1 async reset", outs(), 8'h00);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule